// File: doc/BRIEF.md
# Ray coherence queue gatherer

This block collects ray-versus-node hit events and groups them by node address. Each accepted event carries a ray identifier and the memory address of the hierarchy node that the ray hit. Rays that hit the same node are placed in one queue, so that a later stage can fetch that node once and test the whole group against it. A queue therefore stands for a node address to be read later, together with the list of rays waiting on it.

Partly filled queues wait in a small associative cache keyed by node address. A queue that reaches its capacity leaves the cache at once and goes onto a ready stack, from which queues are dispatched newest first. When a new address arrives and the cache has no free slot, the queue that has waited longest is pushed to the stack to make room. A flush input drains every partial queue to the stack at the end of a frame.

For each ray the block counts the queues that hold it. The count rises when the ray is appended and falls when a queue holding it is dispatched. A ray whose count returns to zero on a dispatch has left every queue, and the block reports it as finished.

Top module: `coh_gather`

## Requirements
- R1: After reset no queue is offered (q_valid_o low), done_mask_o is all zero, and hit_ready_o is high while flush_i is low.
- R2: Accepted hits with equal node address are appended to one queue in arrival order. A dispatched queue carries that address, the number of rays in q_count_o, and ray k (k counted from 0) in q_rays_o bits [k*RAY_W +: RAY_W].
- R3: The hit that brings a queue to QCAP (8) rays removes it from the cache, and the queue is offered on the output in the cycle after that hit is accepted.
- R4: A queue with fewer than QCAP rays is never offered unless it is evicted or flushed.
- R5: With all NCACHE (4) cache slots in use, a hit for an address not in the cache pushes the queue allocated longest ago onto the stack and opens a new queue for the hit.
- R6: The ready stack dispatches the most recently pushed queue first. A queue offered while q_ready_i is low and nothing is pushed keeps its address and count in the next cycle.
- R7: When the stack holds NSTACK (4) queues, a hit that would push a queue (one that fills a queue or needs an eviction) is refused with hit_ready_o low, while a hit that only appends to a cached queue is still accepted.
- R8: While flush_i is high, hit_ready_o is low and, whenever the stack has room, one cached queue per cycle moves to the stack, oldest allocation first.
- R9: Each ray has a membership count, raised on every append and lowered once for each copy of the ray in a dispatched queue. Bit r of done_mask_o pulses for one cycle, in the cycle after the dispatch handshake that brings the count of ray r to zero, and at no other time.
- R10: No two cached queues share a node address.
- R11: A dispatched queue holds between 1 and QCAP rays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hit_valid_i | input | 1 | Hit event present |
| hit_ready_o | output | 1 | Hit event accepted this cycle when valid |
| hit_ray_i | input | RAY_W | Ray identifier of the hit |
| hit_addr_i | input | ADDR_W | Node address of the hit |
| flush_i | input | 1 | Drain all partial queues to the stack |
| q_valid_o | output | 1 | A queue is offered |
| q_ready_i | input | 1 | Consumer takes the offered queue |
| q_addr_o | output | ADDR_W | Node address of the offered queue |
| q_count_o | output | $clog2(QCAP+1) | Number of rays in the offered queue |
| q_rays_o | output | QCAP*RAY_W | Ray identifiers, slot 0 in the low bits |
| done_mask_o | output | 2**RAY_W | One-cycle pulse per ray that has left every queue |

## Verification
On every cycle the assertions check that cached addresses stay unique, that a cached queue is never empty or full, that the stack never takes a push while full, that a filling hit leads to an offered queue, that an offered queue stays still while stalled, that membership counts never go below zero, and that done pulses follow only a dispatch. Which queue is evicted, the newest-first dispatch order, the stall decision with a full stack, the flush drain order and the exact ray lists and done masks can only be shown by the bench's scenarios, which compare every dispatched queue against a transaction model driven by directed and seeded random hit streams.

// File: rtl/coh_pkg.sv
package coh_pkg;
  // Why a queue leaves the cache in a given cycle
  typedef enum logic [1:0] {
    LEAVE_NONE,
    LEAVE_FILL,
    LEAVE_EVICT,
    LEAVE_FLUSH
  } leave_e;
endpackage

// File: rtl/coh_cache.sv
module coh_cache import coh_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int RAY_W  = 4,
  parameter int QCAP   = 8,
  parameter int NCACHE = 4,
  parameter int CNT_W  = $clog2(QCAP + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       look_addr_i,
  input  logic                    ins_en_i,
  input  logic [RAY_W-1:0]        ins_ray_i,
  input  logic                    flush_take_i,
  output logic                    match_o,
  output logic                    fill_o,
  output logic                    full_o,
  output logic                    empty_o,
  output logic                    leave_o,
  output logic [ADDR_W-1:0]       out_addr_o,
  output logic [CNT_W-1:0]        out_cnt_o,
  output logic [QCAP*RAY_W-1:0]   out_rays_o
);
  localparam int IDX_W  = $clog2(NCACHE);
  localparam int SLOT_W = $clog2(QCAP);

  logic [NCACHE-1:0]     vld_q;
  logic [ADDR_W-1:0]     addr_q [NCACHE];
  logic [CNT_W-1:0]      cnt_q  [NCACHE];
  logic [QCAP*RAY_W-1:0] rays_q [NCACHE];
  logic [IDX_W-1:0]      age_q  [NCACHE];  // 0 = newest, dense ranks

  logic [NCACHE-1:0] match_vec;
  logic [IDX_W:0]    nvld;
  logic [IDX_W-1:0]  mi, fi, oi, sel, aslot;
  logic              has_free, append, alloc;
  leave_e            leave;

  always_comb begin
    for (int i = 0; i < NCACHE; i++) match_vec[i] = vld_q[i] && (addr_q[i] == look_addr_i);
  end

  always_comb begin
    nvld = '0;
    for (int i = 0; i < NCACHE; i++) nvld = nvld + (IDX_W+1)'(vld_q[i]);
    mi = '0; fi = '0; oi = '0; has_free = 1'b0;
    for (int i = 0; i < NCACHE; i++) begin
      if (match_vec[i]) mi = IDX_W'(i);
      if (!vld_q[i] && !has_free) begin
        fi = IDX_W'(i);
        has_free = 1'b1;
      end
      if (vld_q[i] && ({1'b0, age_q[i]} == nvld - 1'b1)) oi = IDX_W'(i);
    end
  end

  assign match_o = |match_vec;
  assign full_o  = &vld_q;
  assign empty_o = ~|vld_q;
  assign fill_o  = match_o && (cnt_q[mi] == CNT_W'(QCAP - 1));

  always_comb begin
    leave = LEAVE_NONE;
    sel   = oi;
    if (ins_en_i && match_o && fill_o) begin
      leave = LEAVE_FILL;
      sel   = mi;
    end else if (ins_en_i && !match_o && full_o) begin
      leave = LEAVE_EVICT;
    end else if (flush_take_i && !empty_o) begin
      leave = LEAVE_FLUSH;
    end
  end

  assign leave_o = (leave != LEAVE_NONE);
  assign append  = ins_en_i && match_o && !fill_o;
  assign alloc   = ins_en_i && !match_o;
  assign aslot   = full_o ? oi : fi;

  always_comb begin
    out_addr_o = addr_q[sel];
    out_cnt_o  = cnt_q[sel];
    out_rays_o = rays_q[sel];
    if (leave == LEAVE_FILL) begin
      out_cnt_o = CNT_W'(QCAP);
      out_rays_o[(QCAP-1)*RAY_W +: RAY_W] = ins_ray_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < NCACHE; i++) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
        rays_q[i] <= '0;
        age_q[i]  <= '0;
      end
    end else begin
      if (leave == LEAVE_FILL || leave == LEAVE_FLUSH) begin
        vld_q[sel] <= 1'b0;
        for (int j = 0; j < NCACHE; j++)
          if (vld_q[j] && age_q[j] > age_q[sel]) age_q[j] <= age_q[j] - 1'b1;
      end
      if (alloc) begin
        for (int j = 0; j < NCACHE; j++)
          if (vld_q[j] && IDX_W'(j) != aslot) age_q[j] <= age_q[j] + 1'b1;
        vld_q[aslot]  <= 1'b1;
        addr_q[aslot] <= look_addr_i;
        cnt_q[aslot]  <= CNT_W'(1);
        rays_q[aslot] <= {{((QCAP-1)*RAY_W){1'b0}}, ins_ray_i};
        age_q[aslot]  <= '0;
      end
      if (append) begin
        rays_q[mi][int'(cnt_q[mi][SLOT_W-1:0])*RAY_W +: RAY_W] <= ins_ray_i;
        cnt_q[mi] <= cnt_q[mi] + 1'b1;
      end
    end
  end

  p_unique_addr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));

  p_flush_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_take_i && !ins_en_i && !empty_o) |=> ($countones(vld_q) == $past($countones(vld_q)) - 1));

  for (genvar g = 0; g < NCACHE; g++) begin : g_chk
    p_partial_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_q[g] |-> (cnt_q[g] != '0 && cnt_q[g] < CNT_W'(QCAP)));
  end
endmodule

// File: rtl/coh_stack.sv
module coh_stack #(
  parameter int W     = 52,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic         full_o,
  output logic         empty_o,
  output logic [W-1:0] top_o
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [W-1:0]    mem_q [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic            do_pop, do_push;
  logic [IDX_W-1:0] top_idx, wr_idx;

  assign full_o  = (sp_q == SP_W'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && !full_o;
  assign top_idx = IDX_W'(sp_q - 1'b1);
  assign wr_idx  = IDX_W'(sp_q - SP_W'(do_pop));
  assign top_o   = mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) mem_q[wr_idx] <= push_data_i;
      sp_q <= sp_q + SP_W'(do_push) - SP_W'(do_pop);
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
endmodule

// File: rtl/coh_member.sv
module coh_member #(
  parameter int RAY_W  = 4,
  parameter int QCAP   = 8,
  parameter int MCNT_W = 8,
  parameter int CNT_W  = $clog2(QCAP + 1),
  parameter int NRAY   = 1 << RAY_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  inc_en_i,
  input  logic [RAY_W-1:0]      inc_ray_i,
  input  logic                  dec_en_i,
  input  logic [CNT_W-1:0]      dec_cnt_i,
  input  logic [QCAP*RAY_W-1:0] dec_rays_i,
  output logic [NRAY-1:0]       done_mask_o
);
  for (genvar r = 0; r < NRAY; r++) begin : g_ray
    logic [MCNT_W-1:0] cnt_q, cnt_d, dec_n;
    logic              inc, done_q;

    assign inc = inc_en_i && (inc_ray_i == RAY_W'(r));

    always_comb begin
      dec_n = '0;
      if (dec_en_i)
        for (int k = 0; k < QCAP; k++)
          if (k < int'(dec_cnt_i) && dec_rays_i[k*RAY_W +: RAY_W] == RAY_W'(r))
            dec_n = dec_n + MCNT_W'(1);
      cnt_d = cnt_q + MCNT_W'(inc) - dec_n;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_d;
        done_q <= (dec_n != '0) && (cnt_d == '0);
      end
    end

    assign done_mask_o[r] = done_q;

    p_no_underflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_en_i |-> ((MCNT_W+1)'(cnt_q) + (MCNT_W+1)'(inc) >= (MCNT_W+1)'(dec_n)));
  end

  p_done_after_dispatch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_mask_o) |-> $past(dec_en_i));
endmodule

// File: rtl/coh_gather.sv
module coh_gather #(
  parameter int RAY_W  = 4,
  parameter int ADDR_W = 16,
  parameter int QCAP   = 8,
  parameter int NCACHE = 4,
  parameter int NSTACK = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                hit_valid_i,
  output logic                                hit_ready_o,
  input  logic [RAY_W-1:0]                    hit_ray_i,
  input  logic [ADDR_W-1:0]                   hit_addr_i,
  input  logic                                flush_i,
  output logic                                q_valid_o,
  input  logic                                q_ready_i,
  output logic [ADDR_W-1:0]                   q_addr_o,
  output logic [$clog2(QCAP+1)-1:0]           q_count_o,
  output logic [QCAP*RAY_W-1:0]               q_rays_o,
  output logic [(1<<RAY_W)-1:0]               done_mask_o
);
  localparam int CNT_W  = $clog2(QCAP + 1);
  localparam int NRAY   = 1 << RAY_W;
  localparam int PW     = ADDR_W + CNT_W + QCAP * RAY_W;
  localparam int MCNT_W = $clog2(QCAP * (NCACHE + NSTACK) + 1) + 1;

  logic c_match, c_fill, c_full, c_empty, c_leave;
  logic [ADDR_W-1:0]     c_addr;
  logic [CNT_W-1:0]      c_cnt;
  logic [QCAP*RAY_W-1:0] c_rays;
  logic s_full, s_empty;
  logic [PW-1:0] s_top;
  logic need_push, hit_fire, flush_move, pop;

  assign need_push   = c_match ? c_fill : c_full;
  assign hit_ready_o = !flush_i && (!need_push || !s_full);
  assign hit_fire    = hit_valid_i && hit_ready_o;
  assign flush_move  = flush_i && !c_empty && !s_full;
  assign q_valid_o   = !s_empty;
  assign pop         = q_valid_o && q_ready_i;
  assign {q_addr_o, q_count_o, q_rays_o} = s_top;

  coh_cache #(
    .ADDR_W(ADDR_W), .RAY_W(RAY_W), .QCAP(QCAP), .NCACHE(NCACHE), .CNT_W(CNT_W)
  ) u_cache (
    .clk_i, .rst_ni,
    .look_addr_i (hit_addr_i),
    .ins_en_i    (hit_fire),
    .ins_ray_i   (hit_ray_i),
    .flush_take_i(flush_move),
    .match_o     (c_match),
    .fill_o      (c_fill),
    .full_o      (c_full),
    .empty_o     (c_empty),
    .leave_o     (c_leave),
    .out_addr_o  (c_addr),
    .out_cnt_o   (c_cnt),
    .out_rays_o  (c_rays)
  );

  coh_stack #(.W(PW), .DEPTH(NSTACK)) u_stack (
    .clk_i, .rst_ni,
    .push_i     (c_leave),
    .push_data_i({c_addr, c_cnt, c_rays}),
    .pop_i      (pop),
    .full_o     (s_full),
    .empty_o    (s_empty),
    .top_o      (s_top)
  );

  coh_member #(
    .RAY_W(RAY_W), .QCAP(QCAP), .MCNT_W(MCNT_W), .CNT_W(CNT_W), .NRAY(NRAY)
  ) u_member (
    .clk_i, .rst_ni,
    .inc_en_i   (hit_fire),
    .inc_ray_i  (hit_ray_i),
    .dec_en_i   (pop),
    .dec_cnt_i  (q_count_o),
    .dec_rays_i (q_rays_o),
    .done_mask_o(done_mask_o)
  );

  p_fill_dispatch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_fire && c_match && c_fill) |=> q_valid_o);

  p_hold_offer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_valid_o && !q_ready_i && !c_leave) |=> ($stable(q_addr_o) && $stable(q_count_o)));

  p_count_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o |-> (q_count_o != '0 && q_count_o <= CNT_W'(QCAP)));
endmodule

// File: tb/sim_coh_gather.sv
`timescale 1ns/1ps
module sim_coh_gather;
  localparam int RAY_W = 4, ADDR_W = 16, QCAP = 8, NCACHE = 4, NSTACK = 4;
  localparam int CNT_W = $clog2(QCAP + 1), NRAY = 1 << RAY_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hit_valid = 1'b0, flush = 1'b0, q_ready = 1'b0;
  logic [RAY_W-1:0] hit_ray = '0;
  logic [ADDR_W-1:0] hit_addr = '0;
  logic hit_ready, q_valid;
  logic [ADDR_W-1:0] q_addr;
  logic [CNT_W-1:0] q_count;
  logic [QCAP*RAY_W-1:0] q_rays;
  logic [NRAY-1:0] done_mask;

  always #2 clk = ~clk;

  coh_gather #(.RAY_W(RAY_W), .ADDR_W(ADDR_W), .QCAP(QCAP), .NCACHE(NCACHE), .NSTACK(NSTACK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hit_valid_i(hit_valid), .hit_ready_o(hit_ready),
    .hit_ray_i(hit_ray), .hit_addr_i(hit_addr), .flush_i(flush), .q_valid_o(q_valid),
    .q_ready_i(q_ready), .q_addr_o(q_addr), .q_count_o(q_count), .q_rays_o(q_rays),
    .done_mask_o(done_mask));

  int errs = 0, checks = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // transaction model
  bit        m_v   [NCACHE];
  int        m_a   [NCACHE];
  int        m_c   [NCACHE];
  int        m_r   [NCACHE][QCAP];
  int        m_seq [NCACHE];
  int        seq_ctr = 0;
  int        s_a   [NSTACK];
  int        s_c   [NSTACK];
  int        s_r   [NSTACK][QCAP];
  int        s_sp = 0;
  int        mem   [NRAY];

  function automatic void m_push(int i);
    s_a[s_sp] = m_a[i];
    s_c[s_sp] = m_c[i];
    for (int k = 0; k < QCAP; k++) s_r[s_sp][k] = m_r[i][k];
    s_sp++;
    m_v[i] = 0;
  endfunction

  function automatic int m_oldest();
    int o = -1;
    for (int i = 0; i < NCACHE; i++)
      if (m_v[i] && (o < 0 || m_seq[i] < m_seq[o])) o = i;
    return o;
  endfunction

  function automatic void m_hit(int ray, int addr);
    int mi = -1, slot = -1;
    mem[ray]++;
    for (int i = 0; i < NCACHE; i++) if (m_v[i] && m_a[i] == addr) mi = i;
    if (mi >= 0) begin
      m_r[mi][m_c[mi]] = ray;
      m_c[mi]++;
      if (m_c[mi] == QCAP) m_push(mi);
    end else begin
      for (int i = NCACHE - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin
        slot = m_oldest();
        m_push(slot);
      end
      m_v[slot] = 1; m_a[slot] = addr; m_c[slot] = 1; m_r[slot][0] = ray;
      m_seq[slot] = seq_ctr++;
    end
  endfunction

  task automatic send_hit(int ray, int addr, string req);
    int w = 0;
    @(negedge clk);
    hit_valid = 1'b1; hit_ray = RAY_W'(ray); hit_addr = ADDR_W'(addr);
    #1;
    while (!hit_ready && w < 50) begin
      @(negedge clk); #1; w++;
    end
    chk(hit_ready === 1'b1, req, "hit_ready", longint'(hit_ready), 1);
    @(posedge clk);
    m_hit(ray, addr);
    #1 hit_valid = 1'b0;
  endtask

  task automatic probe_stall(int ray, int addr, bit exp_rdy, string req);
    @(negedge clk);
    hit_valid = 1'b1; hit_ray = RAY_W'(ray); hit_addr = ADDR_W'(addr);
    #1;
    chk(hit_ready === exp_rdy, req, "hit_ready with full stack", longint'(hit_ready), longint'(exp_rdy));
    if (exp_rdy) begin
      @(posedge clk);
      m_hit(ray, addr);
      #1;
    end
    hit_valid = 1'b0;
  endtask

  task automatic pop_check(string req);
    int t;
    bit [NRAY-1:0] dec, exp_mask;
    @(negedge clk);
    chk(q_valid === 1'b1, req, "q_valid", longint'(q_valid), 1);
    t = s_sp - 1;
    chk(q_addr == ADDR_W'(s_a[t]), req, "q_addr", longint'(q_addr), s_a[t]);
    chk(q_count == CNT_W'(s_c[t]), "R11", "q_count", longint'(q_count), s_c[t]);
    for (int k = 0; k < s_c[t]; k++)
      chk(q_rays[k*RAY_W +: RAY_W] == RAY_W'(s_r[t][k]), "R2", "ray slot",
          longint'(q_rays[k*RAY_W +: RAY_W]), s_r[t][k]);
    dec = '0;
    for (int k = 0; k < s_c[t]; k++) begin
      mem[s_r[t][k]]--;
      dec[s_r[t][k]] = 1'b1;
    end
    exp_mask = '0;
    for (int r = 0; r < NRAY; r++) if (dec[r] && mem[r] == 0) exp_mask[r] = 1'b1;
    s_sp--;
    q_ready = 1'b1;
    @(negedge clk);
    q_ready = 1'b0;
    chk(done_mask == exp_mask, "R9", "done_mask", longint'(done_mask), longint'(exp_mask));
  endtask

  task automatic drain(string req);
    while (s_sp > 0) pop_check(req);
    #1;
    chk(q_valid === 1'b0, "R4", "q_valid after drain", longint'(q_valid), 0);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk(hit_ready === 1'b0, "R8", "hit_ready during flush", longint'(hit_ready), 0);
    repeat (NCACHE + 1) begin
      @(posedge clk);
      if (m_oldest() >= 0 && s_sp < NSTACK) m_push(m_oldest());
    end
    #1 flush = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; errs++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < NCACHE; i++) m_v[i] = 0;
    for (int r = 0; r < NRAY; r++) mem[r] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(q_valid === 1'b0, "R1", "q_valid at reset", longint'(q_valid), 0);
    chk(done_mask === '0, "R1", "done_mask at reset", longint'(done_mask), 0);
    chk(hit_ready === 1'b1, "R1", "hit_ready at reset", longint'(hit_ready), 1);

    // R3 / R4: fill one queue
    for (int i = 0; i < QCAP - 1; i++) send_hit(i, 'h0100, "R2");
    @(negedge clk);
    chk(q_valid === 1'b0, "R4", "partial queue held", longint'(q_valid), 0);
    send_hit(QCAP - 1, 'h0100, "R3");
    drain("R3");

    // R5: eviction of oldest
    for (int i = 0; i < NCACHE; i++) send_hit(8 + i, 'h0200 + i, "R5");
    @(negedge clk);
    chk(q_valid === 1'b0, "R4", "cache full, no output", longint'(q_valid), 0);
    send_hit(12, 'h0204, "R5");
    drain("R5");

    // R7 / R6: fill the stack, then probe stall and LIFO order
    for (int i = 0; i < NSTACK; i++) send_hit(i, 'h0300 + i, "R5");
    probe_stall(1, 'h0305, 1'b0, "R7");
    probe_stall(2, 'h0302, 1'b1, "R7");
    drain("R6");

    // R9: ray in two queues; R8: flush order
    send_hit(13, 'h0302, "R9");
    send_hit(13, 'h0303, "R9");
    do_flush();
    drain("R8");

    // random phase
    for (int n = 0; n < 400; n++) begin
      send_hit(int'($urandom % NRAY), 'h0400 + int'($urandom % 6), "R10");
      drain("R10");
    end
    do_flush();
    drain("R8");
    for (int r = 0; r < NRAY; r++) chk(mem[r] == 0, "R9", "model membership settled", mem[r], 0);
    report();
  end
endmodule